// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Nesting Tracker

This block is the per-processor core of an interrupt controller's handshake with software. When the processor reads the acknowledge register, the tracker decides whether the highest-pending interrupt may preempt the one now being serviced. If it may, the tracker hands back that interrupt's ID, pulses a strobe so the pending state of that ID is cleared, and makes the ID the new running interrupt. A refused or empty acknowledge returns the spurious ID 1023.

Nesting is held as a linked list. Each interrupt owns one link entry, which records the interrupt that was running when it was accepted. A completion write for the running interrupt restores the entry it links to. A completion for an interrupt buried deeper in the chain is spliced out by a short multi-cycle walk, and `busy` is high during that walk. Priorities come from an external lookup port. The arbiter that picks the highest-pending ID and the register bus are outside this block.

Top module: `nest_track`

## Requirements
- R1: After reset, `run_id` is 1023, `run_prio` is 0x100, `busy` is 0 and `pend_clr` is 0. Every link entry starts at 1023.
- R2: If `ack_req` is high while `hp_id` is 1023, or while `hp_id` is not below NUM_IRQ, then `ack_data` is 1023 one cycle later, there is no `pend_clr` pulse, and neither `run_id` nor `run_prio` changes.
- R3: If `hp_id`'s priority (an unsigned value on `prio_val`, lower value is more urgent) is greater than or equal to `run_prio`, the acknowledge is refused in the same way as in R2.
- R4: An accepted acknowledge has four effects one cycle later: `ack_data` and `pend_clr_id` equal the ID, `pend_clr` pulses for one cycle, `run_id` becomes the ID, and `run_prio` becomes its priority.
- R5: Whenever `busy` is low, `run_prio` is 0x100 if `run_id` is 1023, and otherwise it is the looked-up priority of `run_id`.
- R6: A completion whose ID is at or above NUM_IRQ, including 1023, has no effect.
- R7: A completion has no effect while `run_id` is 1023.
- R8: Completing the running ID makes the interrupt it had preempted the running one. Its priority is fetched in one extra busy cycle.
- R9: Completing an ID buried in the chain removes only that ID. The running ID is unchanged, and later completions unwind past the removed ID. Completing an ID that is not in the chain changes nothing.
- R10: The completion ID is `eoi_val[9:0]`, and bits above bit 9 are ignored.
- R11: While `busy` is high, `ack_req` and `eoi_req` are ignored, and `busy` never stays high for more than NUM_IRQ+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_id | input | 10 | Highest-pending ID from the arbiter, 1023 if none |
| prio_id | output | 10 | ID whose priority is being looked up |
| prio_val | input | PRIO_W | Priority of `prio_id`, same cycle |
| ack_req | input | 1 | Acknowledge read strobe |
| ack_data | output | 10 | ID returned by the last acknowledge |
| pend_clr | output | 1 | One-cycle strobe: clear pending state of `pend_clr_id` |
| pend_clr_id | output | 10 | ID whose pending state is to be cleared |
| eoi_req | input | 1 | End-of-interrupt write strobe |
| eoi_val | input | DATA_W | Written completion value |
| run_id | output | 10 | Running interrupt ID, 1023 when idle |
| run_prio | output | PRIO_W+1 | Running priority, 0x100 when idle |
| busy | output | 1 | Completion walk or priority reload in progress |

## Verification
The bench targets several corner cases:
- Acknowledges whose priority equals the running priority. A design that compared with less-or-equal would nest an interrupt at its own level.
- Completion of the bottom entry of a three-deep chain. A walk that stopped early or spliced the wrong entry would leave a stale ID that reappears once the top is completed.
- Completions with junk in the upper bits, with IDs out of range, and with nothing running. A decoder that was too wide or too trusting would unwind the chain.
- An acknowledge pulsed during the walk. A design that honoured it would corrupt the chain while the walk is editing it.

Random mixes are checked against a list model of the active set.

// File: rtl/nest_pkg.sv
package nest_pkg;
   localparam int unsigned ID_W = 10;
   localparam logic [ID_W-1:0] SPUR_ID = 10'd1023;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_WALK   = 2'd1,
      ST_RELOAD = 2'd2
   } nest_st_e;
endpackage

// File: rtl/nest_link_mem.sv
// Link store: one entry per interrupt, holding the ID that was running
// when that interrupt was accepted. Two combinational read ports, one write.
module nest_link_mem import nest_pkg::*; #(
   parameter int DEPTH = 96
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [ID_W-1:0] rd_a_idx,
   output logic [ID_W-1:0] rd_a_data,
   input  logic [ID_W-1:0] rd_b_idx,
   output logic [ID_W-1:0] rd_b_data,
   input  logic            we,
   input  logic [ID_W-1:0] wr_idx,
   input  logic [ID_W-1:0] wr_data
);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [ID_W-1:0] DEPTH_V = ID_W'(DEPTH);

   logic [ID_W-1:0] mem [DEPTH];
   logic            a_ok, b_ok, w_ok;

   generate
      if ((1 << IDX_W) == DEPTH) begin : g_pow2
         // Full index span is legal for the sliced bits; range check still
         // screens IDs above the table.
         assign a_ok = (rd_a_idx < DEPTH_V);
         assign b_ok = (rd_b_idx < DEPTH_V);
         assign w_ok = (wr_idx < DEPTH_V);
      end else begin : g_npow2
         assign a_ok = (rd_a_idx < DEPTH_V);
         assign b_ok = (rd_b_idx < DEPTH_V);
         assign w_ok = (wr_idx < DEPTH_V);
      end
   endgenerate

   assign rd_a_data = a_ok ? mem[rd_a_idx[IDX_W-1:0]] : SPUR_ID;
   assign rd_b_data = b_ok ? mem[rd_b_idx[IDX_W-1:0]] : SPUR_ID;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= SPUR_ID;
      end else if (we && w_ok) begin
         mem[wr_idx[IDX_W-1:0]] <= wr_data;
      end
   end
endmodule

// File: rtl/nest_req_decode.sv
// Combinational request qualification: acknowledge preemption test and
// completion ID extraction.
module nest_req_decode import nest_pkg::*; #(
   parameter int NUM_IRQ = 96,
   parameter int PRIO_W  = 8,
   parameter int DATA_W  = 32
) (
   input  logic [ID_W-1:0]   hp_id,
   input  logic [PRIO_W-1:0] prio_val,
   input  logic [PRIO_W:0]   run_prio,
   input  logic [DATA_W-1:0] eoi_val,
   output logic              ack_take,
   output logic [ID_W-1:0]   eoi_id,
   output logic              eoi_in_range
);
   localparam logic [ID_W-1:0] NUM_V = ID_W'(NUM_IRQ);

   logic unused_eoi_hi;

   generate
      if (DATA_W > ID_W) begin : g_wide
         assign eoi_id        = eoi_val[ID_W-1:0];
         assign unused_eoi_hi = ^eoi_val[DATA_W-1:ID_W];
      end else begin : g_narrow
         assign eoi_id        = ID_W'(eoi_val);
         assign unused_eoi_hi = 1'b0;
      end
   endgenerate

   assign eoi_in_range = (eoi_id < NUM_V);
   assign ack_take     = (hp_id != SPUR_ID) && (hp_id < NUM_V) &&
                         ({1'b0, prio_val} < run_prio);
endmodule

// File: rtl/nest_track.sv
module nest_track import nest_pkg::*; #(
   parameter int NUM_IRQ = 96,
   parameter int PRIO_W  = 8,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [9:0]        hp_id,
   output logic [9:0]        prio_id,
   input  logic [PRIO_W-1:0] prio_val,
   input  logic              ack_req,
   output logic [9:0]        ack_data,
   output logic              pend_clr,
   output logic [9:0]        pend_clr_id,
   input  logic              eoi_req,
   input  logic [DATA_W-1:0] eoi_val,
   output logic [9:0]        run_id,
   output logic [PRIO_W:0]   run_prio,
   output logic              busy
);
   localparam int STEP_W = $clog2(NUM_IRQ + 1);
   localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(NUM_IRQ - 1);
   localparam logic [PRIO_W:0]   RP_IDLE   = {1'b1, {PRIO_W{1'b0}}};

   generate
      if (NUM_IRQ < 2 || NUM_IRQ > 1020) begin : g_bad_num
         $error("nest_track: NUM_IRQ must lie in 2..1020");
      end
      if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
         $error("nest_track: PRIO_W must lie in 1..8");
      end
      if (DATA_W < ID_W) begin : g_bad_data
         $error("nest_track: DATA_W must hold a full ID");
      end
   endgenerate

   nest_st_e          st_q;
   logic [ID_W-1:0]   run_id_q, cur_q, tgt_q, ack_data_q, pend_id_q;
   logic [PRIO_W:0]   run_prio_q;
   logic [STEP_W-1:0] steps_q;
   logic              pend_clr_q;

   logic              ack_take, eoi_in_range;
   logic [ID_W-1:0]   eoi_id;
   logic [ID_W-1:0]   rd_a_idx, rd_a_data, rd_b_data;
   logic              lm_we;
   logic [ID_W-1:0]   lm_widx, lm_wdata;
   logic              idle, do_ack, do_eoi;

   assign idle   = (st_q == ST_IDLE);
   assign do_ack = idle && ack_req;
   assign do_eoi = idle && !ack_req && eoi_req && eoi_in_range &&
                   (run_id_q != SPUR_ID);

   nest_req_decode #(
      .NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .DATA_W(DATA_W)
   ) u_dec (
      .hp_id       (hp_id),
      .prio_val    (prio_val),
      .run_prio    (run_prio_q),
      .eoi_val     (eoi_val),
      .ack_take    (ack_take),
      .eoi_id      (eoi_id),
      .eoi_in_range(eoi_in_range)
   );

   // Port A: running entry in idle, walk cursor during the walk.
   assign rd_a_idx = (st_q == ST_WALK) ? cur_q : run_id_q;

   always_comb begin
      lm_we    = 1'b0;
      lm_widx  = hp_id;
      lm_wdata = run_id_q;
      if (do_ack && ack_take) begin
         lm_we = 1'b1;
      end else if (st_q == ST_WALK && rd_a_data == tgt_q &&
                   rd_a_data != SPUR_ID) begin
         lm_we    = 1'b1;
         lm_widx  = cur_q;
         lm_wdata = rd_b_data;
      end
   end

   nest_link_mem #(.DEPTH(NUM_IRQ)) u_links (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_a_idx (rd_a_idx),
      .rd_a_data(rd_a_data),
      .rd_b_idx (tgt_q),
      .rd_b_data(rd_b_data),
      .we       (lm_we),
      .wr_idx   (lm_widx),
      .wr_data  (lm_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         run_id_q   <= SPUR_ID;
         run_prio_q <= RP_IDLE;
         cur_q      <= SPUR_ID;
         tgt_q      <= SPUR_ID;
         steps_q    <= '0;
         ack_data_q <= SPUR_ID;
         pend_clr_q <= 1'b0;
         pend_id_q  <= SPUR_ID;
      end else begin
         pend_clr_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (do_ack) begin
                  if (ack_take) begin
                     ack_data_q <= hp_id;
                     pend_clr_q <= 1'b1;
                     pend_id_q  <= hp_id;
                     run_id_q   <= hp_id;
                     run_prio_q <= {1'b0, prio_val};
                  end else begin
                     ack_data_q <= SPUR_ID;
                  end
               end else if (do_eoi) begin
                  if (eoi_id == run_id_q) begin
                     run_id_q <= rd_a_data;
                     st_q     <= ST_RELOAD;
                  end else begin
                     cur_q   <= run_id_q;
                     tgt_q   <= eoi_id;
                     steps_q <= '0;
                     st_q    <= ST_WALK;
                  end
               end
            end
            ST_WALK: begin
               if (rd_a_data == SPUR_ID || rd_a_data == tgt_q ||
                   steps_q == STEP_LAST) begin
                  st_q <= ST_IDLE;
               end else begin
                  cur_q   <= rd_a_data;
                  steps_q <= steps_q + 1'b1;
               end
            end
            ST_RELOAD: begin
               run_prio_q <= (run_id_q == SPUR_ID) ? RP_IDLE : {1'b0, prio_val};
               st_q       <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign prio_id     = (st_q == ST_RELOAD) ? run_id_q : hp_id;
   assign ack_data    = ack_data_q;
   assign pend_clr    = pend_clr_q;
   assign pend_clr_id = pend_id_q;
   assign run_id      = run_id_q;
   assign run_prio    = run_prio_q;
   assign busy        = !idle;
endmodule

// File: rtl/nest_track_chk.sv
module nest_track_chk #(
   parameter int NUM_IRQ = 96,
   parameter int PRIO_W  = 8,
   parameter int DATA_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [9:0]        hp_id,
   input logic              ack_req,
   input logic [9:0]        ack_data,
   input logic              pend_clr,
   input logic [9:0]        pend_clr_id,
   input logic              eoi_req,
   input logic [DATA_W-1:0] eoi_val,
   input logic [9:0]        run_id,
   input logic [PRIO_W:0]   run_prio,
   input logic              busy
);
   localparam logic [PRIO_W:0] RP_IDLE = {1'b1, {PRIO_W{1'b0}}};
   localparam logic [9:0]      NUM_V   = 10'(NUM_IRQ);

   logic [10:0] busy_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_cnt <= '0;
      else if (busy) busy_cnt <= busy_cnt + 1'b1;
      else           busy_cnt <= '0;
   end

   a_r1_reset_idle: assert property (@(posedge clk)
      $rose(rst_n) |-> (run_id == 10'd1023) && !busy && !pend_clr);

   a_r2_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req && !busy && hp_id == 10'd1023)
      |=> (ack_data == 10'd1023) && !pend_clr && $stable(run_id) && $stable(run_prio));

   a_r4_ack_sets_running: assert property (@(posedge clk) disable iff (!rst_n)
      pend_clr |-> (run_id == pend_clr_id) && (ack_data == pend_clr_id) &&
                   (run_prio < RP_IDLE));

   a_r5_idle_prio: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && run_id == 10'd1023) |-> (run_prio == RP_IDLE));

   a_r6_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_req && !ack_req && !busy && eoi_val[9:0] >= NUM_V)
      |=> $stable(run_id) && !busy);

   a_r7_nothing_running: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_req && !ack_req && !busy && run_id == 10'd1023)
      |=> (run_id == 10'd1023) && !busy);

   a_r11_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      busy_cnt <= 11'(NUM_IRQ + 1));

   a_r11_no_clear_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !pend_clr);
endmodule

bind nest_track nest_track_chk #(
   .NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .DATA_W(DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hp_id      (hp_id),
   .ack_req    (ack_req),
   .ack_data   (ack_data),
   .pend_clr   (pend_clr),
   .pend_clr_id(pend_clr_id),
   .eoi_req    (eoi_req),
   .eoi_val    (eoi_val),
   .run_id     (run_id),
   .run_prio   (run_prio),
   .busy       (busy)
);

// File: tb/sim_nest_track.sv
module sim_nest_track;
   localparam int NI = 96;
   localparam int PW = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  hp_id = 10'd1023;
   logic        ack_req = 1'b0;
   logic        eoi_req = 1'b0;
   logic [31:0] eoi_val = '0;
   logic [PW-1:0] prio_val;
   logic [9:0]  prio_id, ack_data, pend_clr_id, run_id;
   logic        pend_clr, busy;
   logic [PW:0] run_prio;

   always #2.5 clk = ~clk;

   nest_track #(.NUM_IRQ(NI), .PRIO_W(PW), .DATA_W(32)) u0 (
      .clk(clk), .rst_n(rst_n), .hp_id(hp_id), .prio_id(prio_id),
      .prio_val(prio_val), .ack_req(ack_req), .ack_data(ack_data),
      .pend_clr(pend_clr), .pend_clr_id(pend_clr_id), .eoi_req(eoi_req),
      .eoi_val(eoi_val), .run_id(run_id), .run_prio(run_prio), .busy(busy)
   );

   function automatic logic [PW-1:0] ptab(int i);
      return PW'((i * 37 + 11) % 251);
   endfunction

   always_comb prio_val = ptab(int'(prio_id));

   int checks = 0;
   int errors = 0;
   int stk [0:127];
   int depth = 0;
   bit done = 1'b0;

   function automatic int exp_id();
      return (depth == 0) ? 1023 : stk[depth-1];
   endfunction

   function automatic int exp_prio();
      return (depth == 0) ? 256 : int'(ptab(stk[depth-1]));
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic model_remove(int e);
      int k;
      k = -1;
      for (int i = 0; i < depth; i++) if (stk[i] == e) k = i;
      if (k >= 0) begin
         for (int i = k; i < depth - 1; i++) stk[i] = stk[i+1];
         depth--;
      end
   endtask

   task automatic wait_idle();
      for (int n = 0; n < 300 && busy; n++) @(negedge clk);
   endtask

   task automatic do_ack(int id, string req);
      bit take;
      take = (id < NI) && (int'(ptab(id)) < exp_prio());
      @(negedge clk);
      hp_id = 10'(id);
      ack_req = 1'b1;
      @(negedge clk);
      ack_req = 1'b0;
      hp_id = 10'd1023;
      if (take) begin
         stk[depth] = id;
         depth++;
      end
      chk(req, int'(ack_data), take ? id : 1023);
      chk(req, int'(pend_clr), int'(take));
      if (take) chk(req, int'(pend_clr_id), id);
      chk(req, int'(run_id), exp_id());
      chk(req, int'(run_prio), exp_prio());
   endtask

   task automatic do_eoi(logic [31:0] v, string req);
      int e;
      e = int'(v[9:0]);
      @(negedge clk);
      eoi_req = 1'b1;
      eoi_val = v;
      @(negedge clk);
      eoi_req = 1'b0;
      wait_idle();
      if (e < NI && depth > 0) model_remove(e);
      chk(req, int'(busy), 0);
      chk(req, int'(run_id), exp_id());
      chk(req, int'(run_prio), exp_prio());
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", int'(run_id), 1023);
      chk("R1", int'(run_prio), 256);
      chk("R1", int'(busy), 0);
      chk("R1", int'(pend_clr), 0);

      do_eoi(32'd5, "R7");          // nothing running
      do_ack(1023, "R2");           // empty acknowledge
      do_ack(NI + 3, "R2");         // out-of-range pending ID
      do_ack(5, "R4");              // prio 196
      do_ack(3, "R4");              // prio 122
      do_ack(1, "R4");              // prio 48
      do_ack(2, "R3");              // prio 85 >= 48, refused
      do_ack(1, "R3");              // equal priority, refused
      do_eoi(32'd3, "R9");          // buried middle entry
      chk("R9", int'(run_id), 1);
      do_eoi(32'd40, "R9");         // not in chain
      do_eoi(32'hABC0_0001, "R10"); // upper bits ignored, completes 1
      chk("R8", int'(run_id), 5);
      chk("R8", int'(run_prio), 196);
      do_eoi(32'd1023, "R6");
      do_eoi(32'(NI), "R6");
      chk("R6", int'(run_id), 5);

      // R11: acknowledge pulsed during a walk is ignored
      do_ack(3, "R4");
      do_ack(1, "R4");
      @(negedge clk);
      eoi_req = 1'b1;
      eoi_val = 32'd5;
      @(negedge clk);
      eoi_req = 1'b0;
      chk("R11", int'(busy), 1);
      hp_id = 10'd0;
      ack_req = 1'b1;
      @(negedge clk);
      ack_req = 1'b0;
      hp_id = 10'd1023;
      wait_idle();
      model_remove(5);
      chk("R11", int'(run_id), 1);
      chk("R11", int'(run_prio), 48);
      do_eoi(32'd1, "R8");
      chk("R9", int'(run_id), 3);
      do_eoi(32'd3, "R8");
      chk("R5", int'(run_id), 1023);
      chk("R5", int'(run_prio), 256);

      // constrained random mix
      for (int it = 0; it < 600; it++) begin
         int r, id;
         logic [31:0] v;
         r = int'($urandom % 10);
         if (r < 6) begin
            id = int'($urandom % NI);
            if (($urandom % 16) == 0) id = 1023;
            do_ack(id, "R4");
         end else begin
            r = int'($urandom % 4);
            if (r < 2 && depth > 0) id = stk[$urandom % depth];
            else if (r == 3) id = NI + int'($urandom % (1024 - NI));
            else id = int'($urandom % NI);
            v = {$urandom % 4194304, 10'(id)};
            do_eoi(v, "R9");
         end
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R11 actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule